// File: doc/BRIEF.md
# Two-Level Priority Arbiter for DMA Channels

This block decides which DMA channel the transfer engine serves next. Sixteen channels are split into two groups of eight. Each group has a 1-bit priority, and each channel has a 3-bit priority that is ranked only against the other channels of its own group. When the engine is idle and no grant is outstanding, the arbiter first picks the group with the highest priority that has a pending request. It then picks the channel with the highest priority inside that group. It registers the result as a grant, which holds until the engine reports completion. A hardware acknowledge goes back to the requesting peripheral while its channel holds the grant.

Priority values are meant to be unique, but the block tolerates duplicates. Ties go to the lowest-numbered group or channel, and the arbiter keeps granting without stalling. It also reports the conflict through sticky flags. A group conflict is global: it is raised whenever any request is arbitrated. A channel conflict is checked only inside the group that wins. The channel that was granted is recorded. An error interrupt is raised for that channel if its interrupt is enabled. All settings are written through a synchronous write-only configuration port.

Top module: `dma_grp_arb`

## Requirements
- R1: Configuration writes take effect at the clock edge where `cfg_we` is high, using these addresses:
  - Addresses 0–15 set the priority of channel n from `cfg_wdata[2:0]`.
  - Addresses 16–17 set the priority of group g from `cfg_wdata[0]`.
  - Address 20 is the error clear register. Writing 1 to bit 0 clears the group flag, bit 1 clears the channel flag, and bit 2 resets the recorded channel to 0.
  - Addresses 21 and 22 set the interrupt enables of channels 0–7 and 8–15, one bit per channel, with bit k controlling channel 8·(addr−21)+k.
  - At reset, channel n has priority n mod 8, group g has priority g, and all interrupt enables are 0.
- R2: After reset, `gnt_valid`, `ack`, `err_grp`, `err_chn`, `err_ch` and `err_irq` are all zero.
- R3: Channel n belongs to group n/8. The active group is the group with the numerically largest priority among the groups with at least one request bit set. A lower group is chosen only when no higher group has a request.
- R4: Inside the active group, the winner is the requesting channel with the numerically largest priority.
- R5: A group tie goes to the lower group number, and a channel tie goes to the lower channel number.
- R6: An arbitration happens on a clock edge where `eng_idle` is high, `gnt_valid` is low and at least one request is set. After that edge, `gnt_valid` is 1 and `gnt_ch` holds the winner. Both stay unchanged until an edge with `eng_done` high, after which `gnt_valid` is 0. No grant is issued while `eng_idle` is low.
- R7: `ack[n]` is 1 exactly when `gnt_valid` is 1, `gnt_ch` equals n, and `req[n]` is currently 1.
- R8: At an arbitration, if both groups have the same priority, `err_grp` is set. The flag is sticky.
- R9: At an arbitration, if any two channels of the winning group have the same priority, `err_chn` is set. The flag is sticky. Duplicates in a group that does not win set nothing.
- R10: At an arbitration that sets either flag, `err_ch` records the granted channel.
- R11: The flags and `err_ch` hold until they are cleared through address 20 as described in R1. If a clear and a new error happen in the same cycle, the new error wins.
- R12: `err_irq` is 1 exactly when at least one flag is set and the interrupt enable of the channel in `err_ch` is 1.
- R13: While error flags are set, arbitration and grants continue normally under R3–R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | Per-channel service requests |
| eng_idle | input | 1 | Engine can accept a new grant |
| eng_done | input | 1 | Engine finished the granted channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| gnt_valid | output | 1 | Grant is held |
| gnt_ch | output | 4 | Granted channel number |
| ack | output | 16 | Per-channel hardware acknowledge |
| err_grp | output | 1 | Sticky group-priority conflict flag |
| err_chn | output | 1 | Sticky channel-priority conflict flag |
| err_ch | output | 4 | Channel recorded with the last error |
| err_irq | output | 1 | Error interrupt |

## Verification
A corrupted priority register or a wrong tie-break shows up as a wrong `gnt_ch` at the first arbitration that touches the affected group, one cycle after the arbitration edge. A faulty grant register shows up either as `gnt_valid` dropping before `eng_done` or as the grant staying held after it. Error state that is wrong appears on `err_grp`, `err_chn` or `err_ch` in the same cycle as the grant. It also appears one cycle after a clear write, through a flag that survives the clear or one that clears too much. A wrong enable bit shows up only on `err_irq`, and only while the recorded channel is that channel.

// File: rtl/dma_grp_arb_pkg.sv
// Package: shared sizes and configuration map of the grouped DMA arbiter.
// Assumes addresses fit in CFG_AW bits and that the enable bytes follow the
// clear register.
package dma_grp_arb_pkg;
    localparam int DEF_GROUPS   = 2;
    localparam int DEF_CH_PER_G = 8;
    localparam int DEF_GPRI_W   = 1;
    localparam int DEF_CPRI_W   = 3;
    localparam int CFG_AW       = 5;
    localparam int CFG_DW       = 8;
    localparam int CLR_ADDR     = 20;
    localparam int EN_BASE      = 21;
    localparam int CLR_GRP_BIT  = 0;
    localparam int CLR_CHN_BIT  = 1;
    localparam int CLR_NUM_BIT  = 2;
endpackage

// File: rtl/dma_grp_arb_pick.sv
// Picks the valid entry with the largest priority value. Equal values go to
// the lowest index. Purely combinational; assumes N >= 1.
module dma_grp_arb_pick #(
    parameter int N     = 8,
    parameter int W     = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   valid,
    input  logic [N*W-1:0] pri_flat,
    output logic           found,
    output logic [IDX_W-1:0] idx
);
    logic [W-1:0] best;

    // Linear scan; strict greater-than keeps the lowest index on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!found || pri_flat[i*W +: W] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = pri_flat[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/dma_grp_arb_dup.sv
// Flags any two entries whose priority values are equal. Pairwise compare,
// N*(N-1)/2 comparators; combinational.
module dma_grp_arb_dup #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N*W-1:0] pri_flat,
    output logic           dup
);
    // OR of all pairwise equalities.
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (pri_flat[i*W +: W] == pri_flat[j*W +: W]) dup = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_grp_arb.sv
// Two-level fixed-priority DMA channel arbiter.
// - Picks a group, then a channel inside it, whenever the engine is idle and
//   no grant is held.
// - Holds the grant until the engine signals done.
// - Flags duplicated group and channel priorities, records the granted
//   channel and drives a maskable error interrupt.
// Assumes the engine drops eng_idle while it works on a grant.
module dma_grp_arb
    import dma_grp_arb_pkg::*;
#(
    parameter int GROUPS   = DEF_GROUPS,
    parameter int CH_PER_G = DEF_CH_PER_G,
    parameter int GPRI_W   = DEF_GPRI_W,
    parameter int CPRI_W   = DEF_CPRI_W,
    localparam int NCH     = GROUPS * CH_PER_G,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int GSEL_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int LOC_W   = (CH_PER_G > 1) ? $clog2(CH_PER_G) : 1,
    localparam int GRP_BASE = NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  logic              eng_idle,
    input  logic              eng_done,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              gnt_valid,
    output logic [CH_W-1:0]   gnt_ch,
    output logic [NCH-1:0]    ack,
    output logic              err_grp,
    output logic              err_chn,
    output logic [CH_W-1:0]   err_ch,
    output logic              err_irq
);
    logic [CPRI_W-1:0]        ch_pri  [NCH];
    logic [GPRI_W-1:0]        grp_pri [GROUPS];
    logic [NCH-1:0]           irq_en;
    logic [GROUPS-1:0]        grp_any;
    logic [GROUPS*GPRI_W-1:0] grp_flat;
    logic [GROUPS-1:0]        loc_found;
    logic [LOC_W-1:0]         loc_idx [GROUPS];
    logic [GROUPS-1:0]        ch_dup;
    logic                     grp_dup, grp_found, arb_go;
    logic [GSEL_W-1:0]        grp_idx;
    logic [CH_W-1:0]          win_ch;
    logic                     clr_wr;

    // Configuration registers: priorities and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) ch_pri[i] <= CPRI_W'(i % CH_PER_G);
            for (int g = 0; g < GROUPS; g++) grp_pri[g] <= GPRI_W'(g);
            irq_en <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NCH; i++) begin
                if (cfg_addr == CFG_AW'(i)) ch_pri[i] <= cfg_wdata[CPRI_W-1:0];
                if (cfg_addr == CFG_AW'(EN_BASE + i / CFG_DW))
                    irq_en[i] <= cfg_wdata[i % CFG_DW];
            end
            for (int g = 0; g < GROUPS; g++)
                if (cfg_addr == CFG_AW'(GRP_BASE + g)) grp_pri[g] <= cfg_wdata[GPRI_W-1:0];
        end
    end

    // Per-group request OR, channel winner and duplicate check.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CH_PER_G*CPRI_W-1:0] cp_flat;
        for (genvar l = 0; l < CH_PER_G; l++) begin : g_ch
            assign cp_flat[l*CPRI_W +: CPRI_W] = ch_pri[g*CH_PER_G + l];
        end
        assign grp_any[g] = |req[g*CH_PER_G +: CH_PER_G];
        assign grp_flat[g*GPRI_W +: GPRI_W] = grp_pri[g];

        dma_grp_arb_pick #(.N(CH_PER_G), .W(CPRI_W)) u_cpick (
            .valid(req[g*CH_PER_G +: CH_PER_G]), .pri_flat(cp_flat),
            .found(loc_found[g]), .idx(loc_idx[g]));
        dma_grp_arb_dup #(.N(CH_PER_G), .W(CPRI_W)) u_cdup (
            .pri_flat(cp_flat), .dup(ch_dup[g]));
    end

    dma_grp_arb_pick #(.N(GROUPS), .W(GPRI_W)) u_gpick (
        .valid(grp_any), .pri_flat(grp_flat), .found(grp_found), .idx(grp_idx));
    dma_grp_arb_dup #(.N(GROUPS), .W(GPRI_W)) u_gdup (
        .pri_flat(grp_flat), .dup(grp_dup));

    assign win_ch = CH_W'(grp_idx) * CH_W'(CH_PER_G) + CH_W'(loc_idx[grp_idx]);
    assign arb_go = eng_idle && !gnt_valid && grp_found && loc_found[grp_idx];
    assign clr_wr = cfg_we && (cfg_addr == CFG_AW'(CLR_ADDR));

    // Grant register: load on arbitration, release on engine done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_ch    <= '0;
        end else if (arb_go) begin
            gnt_valid <= 1'b1;
            gnt_ch    <= win_ch;
        end else if (gnt_valid && eng_done) begin
            gnt_valid <= 1'b0;
        end
    end

    // Sticky error state: write-one clear first, a new error overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_grp <= 1'b0;
            err_chn <= 1'b0;
            err_ch  <= '0;
        end else begin
            if (clr_wr && cfg_wdata[CLR_GRP_BIT]) err_grp <= 1'b0;
            if (clr_wr && cfg_wdata[CLR_CHN_BIT]) err_chn <= 1'b0;
            if (clr_wr && cfg_wdata[CLR_NUM_BIT]) err_ch  <= '0;
            if (arb_go && grp_dup)         err_grp <= 1'b1;
            if (arb_go && ch_dup[grp_idx]) err_chn <= 1'b1;
            if (arb_go && (grp_dup || ch_dup[grp_idx])) err_ch <= win_ch;
        end
    end

    // Acknowledge follows the granted channel and its live request.
    always_comb begin
        ack = '0;
        if (gnt_valid) ack[gnt_ch] = req[gnt_ch];
    end

    // Interrupt gated by the enable of the recorded channel.
    assign err_irq = (err_grp || err_chn) && irq_en[err_ch];

    p_grant_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_idle && !gnt_valid && |req) |=> gnt_valid);
    p_no_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && !eng_idle) |=> !gnt_valid);
    p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !eng_done) |=> (gnt_valid && $stable(gnt_ch)));
    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
    p_grp_err_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_grp) |-> $past(|req));
    p_grp_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_grp && !(clr_wr && cfg_wdata[CLR_GRP_BIT])) |=> err_grp);
    p_chn_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_chn && !(clr_wr && cfg_wdata[CLR_CHN_BIT])) |=> err_chn);
    p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (err_grp || err_chn));
endmodule

// File: tb/sim_dma_grp_arb.sv
// Bench: sweeps priority configurations and request patterns and compares
// grant, acknowledge and error outputs against a model built from the
// requirements.
module sim_dma_grp_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        eng_idle = 1'b0, eng_done = 1'b0, cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        gnt_valid, err_grp, err_chn, err_irq;
    logic [3:0]  gnt_ch, err_ch;
    logic [15:0] ack;

    int nchk = 0, nfail = 0;
    int cp[16];
    int gp[2];
    logic [15:0] en = '0;
    bit   e_g = 0, e_c = 0;
    int   e_ch = 0;

    always #5 clk = ~clk;

    dma_grp_arb u0 (.clk, .rst_n, .req, .eng_idle, .eng_done, .cfg_we, .cfg_addr,
                    .cfg_wdata, .gnt_valid, .gnt_ch, .ack, .err_grp, .err_chn,
                    .err_ch, .err_irq);

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_err(input string r);
        chk(err_grp == e_g, {r, " err_grp"}, int'(err_grp), int'(e_g));
        chk(err_chn == e_c, {r, " err_chn"}, int'(err_chn), int'(e_c));
        chk(err_ch == 4'(e_ch), {r, " err_ch"}, int'(err_ch), e_ch);
        chk(err_irq == ((e_g || e_c) && en[e_ch]), "R12 err_irq", int'(err_irq),
            int'((e_g || e_c) && en[e_ch]));
    endtask

    // Expected arbitration from R3-R5, R8, R9.
    task automatic model(input logic [15:0] r, output bit v, output int ch,
                         output bit ge, output bit ce);
        int bg = -1;
        int bc = -1;
        for (int g = 0; g < 2; g++)
            if ((r[g*8 +: 8] != 0) && (bg < 0 || gp[g] > gp[bg])) bg = g;
        v = (bg >= 0); ch = 0; ge = 0; ce = 0;
        if (!v) return;
        for (int l = 0; l < 8; l++)
            if (r[bg*8+l] && (bc < 0 || cp[bg*8+l] > cp[bc])) bc = bg*8 + l;
        ch = bc;
        ge = (gp[0] == gp[1]);
        for (int i = 0; i < 8; i++)
            for (int j = i + 1; j < 8; j++)
                if (cp[bg*8+i] == cp[bg*8+j]) ce = 1;
    endtask

    task automatic vec(input logic [15:0] r, input bit do_clr);
        bit v, ge, ce;
        int ch;
        @(negedge clk);
        req = r; eng_idle = 1'b1;
        model(r, v, ch, ge, ce);
        @(negedge clk);
        eng_idle = 1'b0;
        chk(gnt_valid == v, "R6 grant issued", int'(gnt_valid), int'(v));
        if (v) begin
            e_g = e_g | ge; e_c = e_c | ce;
            if (ge || ce) e_ch = ch;
            chk(gnt_ch == 4'(ch), "R3/R4/R5 winner", int'(gnt_ch), ch);
            chk(ack == 16'(1 << ch), "R7 ack", int'(ack), 1 << ch);
        end
        chk_err("R8/R9/R10/R13");
        if (v) begin
            req = r & ~16'(1 << ch);
            #1;
            chk(ack == 16'h0, "R7 ack follows req", int'(ack), 0);
            @(negedge clk);
            chk(gnt_valid && gnt_ch == 4'(ch), "R6 grant held", int'(gnt_ch), ch);
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            chk(gnt_valid == 1'b0, "R6 release on done", int'(gnt_valid), 0);
            chk_err("R11 sticky");
        end
        req = '0;
        if (do_clr) begin
            cfg_wr(20, 1);
            e_g = 0;
            chk_err("R11 partial clear");
            cfg_wr(20, 6);
            e_c = 0; e_ch = 0;
            chk_err("R11 full clear");
        end
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) cp[i] = i % 8;
        gp[0] = 0; gp[1] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt_valid == 0 && ack == 0, "R2 reset grant", int'(ack), 0);
        chk(!err_grp && !err_chn && err_ch == 0 && !err_irq, "R2 reset errors",
            int'({err_grp, err_chn, err_irq}), 0);
        // R1 reset priorities; R3 group 1 beats group 0.
        vec(16'hFFFF, 1); vec(16'h00FF, 1); vec(16'h0105, 1); vec(16'h8001, 1);
        // R6 no grant while busy.
        req = 16'hFFFF; eng_idle = 1'b0;
        repeat (3) @(negedge clk);
        chk(gnt_valid == 0, "R6 busy no grant", int'(gnt_valid), 0);
        req = '0;
        // Sweep configurations (R1 writes) and request patterns.
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 16; i++) begin
                int g = i / 8, l = i % 8;
                cp[i] = ((c >> g) & 1) ? (((l >> 1) + c) % 8) : ((l * 3 + c) % 8);
                cfg_wr(i, cp[i]);
            end
            gp[0] = (c >> 2) & 1; gp[1] = ((c >> 3) & 1) ^ 1;
            cfg_wr(16, gp[0]); cfg_wr(17, gp[1]);
            en = 16'(c * 16'h3A5D + 16'h1234);
            cfg_wr(21, en[7:0]); cfg_wr(22, en[15:8]);
            for (int k = 0; k < 24; k++) begin
                logic [15:0] r;
                r = 16'((k * 16'h9E37 + c * 16'h03B1) ^ (k << (c % 5)));
                if (k % 6 == 1) r = 16'(1 << ((k + c) % 16));
                if (k == 0) r = '0;
                vec(r, (k % 4) != 3);
            end
            vec(16'h0000, 1);
        end
        // R13: all channels duplicate, groups tied; grants continue with flags set.
        for (int i = 0; i < 16; i++) begin cp[i] = 2; cfg_wr(i, 2); end
        gp[0] = 1; gp[1] = 1; cfg_wr(16, 1); cfg_wr(17, 1);
        en = 16'hFFFF; cfg_wr(21, 8'hFF); cfg_wr(22, 8'hFF);
        vec(16'h0C00, 0); vec(16'h0030, 0); vec(16'h8000, 0); vec(16'h0000, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule